// File: doc/BRIEF.md
# Configuration Index/Data Port with Unlock Key

This block is the configuration front end of a peripheral controller chip. A host reaches it through two byte-wide I/O addresses: an index port at a base address and a data port at the next address. After reset the port is locked. The host opens it by writing a four-byte key to the index port. The last byte of the key depends on which of two base addresses the chip answers at, and that choice comes from a strap pin.

Once the port is open, a write to the index port selects a configuration register. Reads and writes at the data port then reach that register. The register set has a fixed two-byte chip identity, a logical-device selector, a 16-bit I/O base for the serial flash controller, and a global control byte that enables flash memory segments. The port closes again when the host writes an exit value to a dedicated register.

The flash base, the segment enables and the device selector are driven out as ports. A neighbouring flash controller takes its settings from them.

Top module: `cfgp_port`

## Requirements
- R1: After a synchronous reset the port is locked, `ldn_sel` is 0x00, `flash_io_base` equals the parameter `FBASE_RST` (default 0x0820), and all six segment-control outputs are 0.
- R2: The port opens after four index-port writes of 0x87, 0x01, 0x55 and a final byte. The final byte is 0x55 when the strap selects base 0x2E and 0xAA when it selects base 0x4E. The wrong final byte leaves the port locked.
- R3: A locked index-port write that does not match the expected key byte restarts the matcher. If that byte is 0x87, it counts as the first key byte. Otherwise the matcher returns to the start.
- R4: While locked, data-port writes change no register or output, and reads of either port return 0xFF.
- R5: While open, an index-port write selects the register number, and an index-port read returns the selected number.
- R6: Registers 0x20 and 0x21 read 0x87 and 0x16, and data writes to them are ignored.
- R7: Register 0x07 selects the logical device. Registers 0x64 (high byte) and 0x65 (low byte) of logical device 7 hold `flash_io_base`. In any other device those numbers read 0x00 and ignore writes.
- R8: Register 0x24 is the segment control byte: bit0 suspend, bit1 top segment, bit2 second segment, bit3 448 KiB segment, bit4 host write enable, bit5 pin option. Each bit drives its own output, and bits 7:6 read as 0.
- R9: Writing 0x02 to register 0x02 locks the port. Any other value written there keeps it open, and register 0x02 reads 0x00.
- R10: Only the selected base address and the next address are decoded. Writes elsewhere, including the other candidate base, have no effect, and reads elsewhere return 0xFF.
- R11: Read data appears on `host_rdata` on the clock edge that samples `host_rd` and holds until the next read.
- R12: The base choice is latched from `strap_alt_base` only during reset. Changing the strap later does not move the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_alt_base | input | 1 | Base select strap (0: 0x2E, 1: 0x4E), sampled in reset |
| host_wr | input | 1 | Host byte write strobe |
| host_rd | input | 1 | Host byte read strobe |
| host_addr | input | 16 | Host I/O address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered read data |
| cfg_open | output | 1 | Port unlocked |
| ldn_sel | output | 8 | Selected logical device |
| flash_io_base | output | 16 | Flash controller I/O base |
| seg_suspend | output | 1 | Segment control bit 0 |
| seg_top_en | output | 1 | Top segment and low alias enable |
| seg_mid_en | output | 1 | Second 128 KiB segment enable |
| seg_448_en | output | 1 | 448 KiB segment enable |
| flash_host_wr_en | output | 1 | Host writes to flash enabled |
| flash_pin_alt | output | 1 | Flash pin option select |

## Verification
Every write takes effect on the clock edge that samples the strobe. Lock state, register contents and the exported outputs are therefore checked on the falling edge that follows. A read result is registered on the edge that samples `host_rd`. The read task queues its expected byte, and the monitor compares it on the falling edge after the next rising edge. The monitor fires only when it saw a read strobe at that rising edge, so each comparison lands exactly one cycle after its read.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
    typedef logic [7:0] byte_t;

    localparam int    KEY_LEN      = 4;
    localparam byte_t KEY_B0       = 8'h87;
    localparam byte_t KEY_B1       = 8'h01;
    localparam byte_t KEY_B2       = 8'h55;
    localparam byte_t KEY_LAST_PRI = 8'h55;
    localparam byte_t KEY_LAST_ALT = 8'hAA;

    localparam byte_t REG_EXIT     = 8'h02;
    localparam byte_t EXIT_VAL     = 8'h02;
    localparam byte_t REG_LDN      = 8'h07;
    localparam byte_t REG_ID_HI    = 8'h20;
    localparam byte_t REG_ID_LO    = 8'h21;
    localparam byte_t REG_SEGCTL   = 8'h24;
    localparam byte_t REG_FBASE_HI = 8'h64;
    localparam byte_t REG_FBASE_LO = 8'h65;
    localparam byte_t IDLE_BUS     = 8'hFF;

    typedef enum logic [1:0] {
        PORT_NONE  = 2'd0,
        PORT_INDEX = 2'd1,
        PORT_DATA  = 2'd2
    } port_sel_e;

    // bit 5 .. bit 0 of the segment control byte
    typedef struct packed {
        logic pin_alt;
        logic host_wr_en;
        logic seg448_en;
        logic mid_en;
        logic top_en;
        logic suspend;
    } seg_ctl_t;

    typedef struct packed {
        logic      wr;
        logic      rd;
        port_sel_e port;
        byte_t     data;
    } host_op_t;

    function automatic byte_t key_byte(input int unsigned step, input logic alt);
        byte_t b;
        case (step)
            0:       b = KEY_B0;
            1:       b = KEY_B1;
            2:       b = KEY_B2;
            default: b = alt ? KEY_LAST_ALT : KEY_LAST_PRI;
        endcase
        return b;
    endfunction

    function automatic byte_t seg_to_byte(input seg_ctl_t s);
        return {2'b00, s};
    endfunction
endpackage

// File: rtl/cfgp_decode.sv
module cfgp_decode
    import cfgp_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] BASE_PRI = 16'h002E,
    parameter logic [ADDR_W-1:0] BASE_ALT = 16'h004E
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strap_alt,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  byte_t             host_wdata,
    output host_op_t          op,
    output logic              alt_base
);
    logic              alt_q;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] base_nxt;

    always_ff @(posedge clk) begin
        if (rst) alt_q <= strap_alt;
    end

    assign base     = alt_q ? BASE_ALT : BASE_PRI;
    assign base_nxt = base + ADDR_W'(1);
    assign alt_base = alt_q;

    always_comb begin
        op.wr   = host_wr;
        op.rd   = host_rd;
        op.data = host_wdata;
        if (host_addr == base)          op.port = PORT_INDEX;
        else if (host_addr == base_nxt) op.port = PORT_DATA;
        else                            op.port = PORT_NONE;
    end
endmodule

// File: rtl/cfgp_key.sv
module cfgp_key
    import cfgp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  alt_base,
    input  logic  idx_wr,
    input  byte_t wdata,
    input  logic  exit_req,
    output logic  open
);
    localparam int SW = $clog2(KEY_LEN);
    localparam logic [SW-1:0] LAST = SW'(KEY_LEN - 1);

    logic [SW-1:0] step_q;
    logic          open_q;
    byte_t         want;

    assign want = key_byte(int'(step_q), alt_base);

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= '0;
            open_q <= 1'b0;
        end else if (open_q) begin
            if (exit_req) begin
                open_q <= 1'b0;
                step_q <= '0;
            end
        end else if (idx_wr) begin
            if (wdata == want) begin
                if (step_q == LAST) begin
                    open_q <= 1'b1;
                    step_q <= '0;
                end else begin
                    step_q <= step_q + SW'(1);
                end
            end else if (wdata == KEY_B0) begin
                step_q <= SW'(1);
            end else begin
                step_q <= '0;
            end
        end
    end

    assign open = open_q;
endmodule

// File: rtl/cfgp_regs.sv
module cfgp_regs
    import cfgp_pkg::*;
#(
    parameter byte_t       FLASH_LDN = 8'h07,
    parameter logic [15:0] CHIP_ID   = 16'h8716,
    parameter logic [15:0] FBASE_RST = 16'h0820
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        open,
    input  host_op_t    op,
    output byte_t       rdata,
    output logic        exit_req,
    output byte_t       index,
    output byte_t       ldn,
    output logic [15:0] fbase,
    output seg_ctl_t    seg
);
    byte_t       index_q;
    byte_t       ldn_q;
    logic [15:0] fbase_q;
    seg_ctl_t    seg_q;
    byte_t       rdata_q;
    byte_t       rd_mux;
    logic        dwr;
    logic        iwr;
    logic        flash_dev;

    assign iwr       = open && op.wr && (op.port == PORT_INDEX);
    assign dwr       = open && op.wr && (op.port == PORT_DATA);
    assign flash_dev = (ldn_q == FLASH_LDN);
    assign exit_req  = dwr && (index_q == REG_EXIT) && (op.data == EXIT_VAL);

    always_ff @(posedge clk) begin
        if (rst) begin
            index_q <= '0;
            ldn_q   <= '0;
            fbase_q <= FBASE_RST;
            seg_q   <= '0;
        end else begin
            if (iwr) index_q <= op.data;
            if (dwr) begin
                case (index_q)
                    REG_LDN:    ldn_q <= op.data;
                    REG_SEGCTL: seg_q <= seg_ctl_t'(op.data[5:0]);
                    REG_FBASE_HI: if (flash_dev) fbase_q[15:8] <= op.data;
                    REG_FBASE_LO: if (flash_dev) fbase_q[7:0]  <= op.data;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (index_q)
            REG_LDN:      rd_mux = ldn_q;
            REG_ID_HI:    rd_mux = CHIP_ID[15:8];
            REG_ID_LO:    rd_mux = CHIP_ID[7:0];
            REG_SEGCTL:   rd_mux = seg_to_byte(seg_q);
            REG_FBASE_HI: rd_mux = flash_dev ? fbase_q[15:8] : 8'h00;
            REG_FBASE_LO: rd_mux = flash_dev ? fbase_q[7:0]  : 8'h00;
            default:      rd_mux = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= IDLE_BUS;
        end else if (op.rd) begin
            if (!open)                      rdata_q <= IDLE_BUS;
            else if (op.port == PORT_INDEX) rdata_q <= index_q;
            else if (op.port == PORT_DATA)  rdata_q <= rd_mux;
            else                            rdata_q <= IDLE_BUS;
        end
    end

    assign rdata = rdata_q;
    assign index = index_q;
    assign ldn   = ldn_q;
    assign fbase = fbase_q;
    assign seg   = seg_q;
endmodule

// File: rtl/cfgp_port.sv
module cfgp_port
    import cfgp_pkg::*;
#(
    parameter logic [15:0] BASE_PRI  = 16'h002E,
    parameter logic [15:0] BASE_ALT  = 16'h004E,
    parameter logic [7:0]  FLASH_LDN = 8'h07,
    parameter logic [15:0] CHIP_ID   = 16'h8716,
    parameter logic [15:0] FBASE_RST = 16'h0820
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        strap_alt_base,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [15:0] host_addr,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    output logic        cfg_open,
    output logic [7:0]  ldn_sel,
    output logic [15:0] flash_io_base,
    output logic        seg_suspend,
    output logic        seg_top_en,
    output logic        seg_mid_en,
    output logic        seg_448_en,
    output logic        flash_host_wr_en,
    output logic        flash_pin_alt
);
    host_op_t op;
    logic     alt_base;
    logic     exit_req;
    logic     open;
    byte_t    cur_idx;
    seg_ctl_t seg;

    cfgp_decode #(
        .ADDR_W   (16),
        .BASE_PRI (BASE_PRI),
        .BASE_ALT (BASE_ALT)
    ) u_dec (
        .clk       (clk),
        .rst       (rst),
        .strap_alt (strap_alt_base),
        .host_wr   (host_wr),
        .host_rd   (host_rd),
        .host_addr (host_addr),
        .host_wdata(host_wdata),
        .op        (op),
        .alt_base  (alt_base)
    );

    cfgp_key u_key (
        .clk      (clk),
        .rst      (rst),
        .alt_base (alt_base),
        .idx_wr   (op.wr && (op.port == PORT_INDEX)),
        .wdata    (op.data),
        .exit_req (exit_req),
        .open     (open)
    );

    cfgp_regs #(
        .FLASH_LDN (FLASH_LDN),
        .CHIP_ID   (CHIP_ID),
        .FBASE_RST (FBASE_RST)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .open     (open),
        .op       (op),
        .rdata    (host_rdata),
        .exit_req (exit_req),
        .index    (cur_idx),
        .ldn      (ldn_sel),
        .fbase    (flash_io_base),
        .seg      (seg)
    );

    assign cfg_open         = open;
    assign seg_suspend      = seg.suspend;
    assign seg_top_en       = seg.top_en;
    assign seg_mid_en       = seg.mid_en;
    assign seg_448_en       = seg.seg448_en;
    assign flash_host_wr_en = seg.host_wr_en;
    assign flash_pin_alt    = seg.pin_alt;
endmodule

// File: rtl/cfgp_chk.sv
module cfgp_chk
    import cfgp_pkg::*;
#(
    parameter logic [7:0] FLASH_LDN = 8'h07
) (
    input logic        clk,
    input logic        rst,
    input host_op_t    op,
    input logic [7:0]  cur_idx,
    input logic [7:0]  host_rdata,
    input logic        cfg_open,
    input logic [7:0]  ldn_sel,
    input logic [15:0] flash_io_base,
    input logic [5:0]  seg_bits
);
    AST_LOCKED_READ_IDLE: assert property (@(posedge clk) disable iff (rst)
        (op.rd && !cfg_open) |=> (host_rdata == 8'hFF)); // R4

    AST_LOCKED_STATE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cfg_open |=> ($stable(flash_io_base) && $stable(seg_bits) && $stable(ldn_sel))); // R4

    AST_OPEN_NEEDS_INDEX_WRITE: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_open) |-> $past(op.wr && (op.port == PORT_INDEX))); // R2

    AST_ID_HIGH_BYTE: assert property (@(posedge clk) disable iff (rst)
        (cfg_open && op.rd && (op.port == PORT_DATA) && (cur_idx == REG_ID_HI))
        |=> (host_rdata == 8'h87)); // R6

    AST_EXIT_RELOCKS: assert property (@(posedge clk) disable iff (rst)
        (cfg_open && op.wr && (op.port == PORT_DATA) && (cur_idx == REG_EXIT) && (op.data == EXIT_VAL))
        |=> !cfg_open); // R9

    AST_FOREIGN_LDN_NO_BASE: assert property (@(posedge clk) disable iff (rst)
        (op.wr && (op.port == PORT_DATA) && (ldn_sel != FLASH_LDN) &&
         ((cur_idx == REG_FBASE_HI) || (cur_idx == REG_FBASE_LO)))
        |=> $stable(flash_io_base)); // R7

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !op.rd |=> $stable(host_rdata)); // R11
endmodule

bind cfgp_port cfgp_chk #(.FLASH_LDN(FLASH_LDN)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .op            (op),
    .cur_idx       (cur_idx),
    .host_rdata    (host_rdata),
    .cfg_open      (cfg_open),
    .ldn_sel       (ldn_sel),
    .flash_io_base (flash_io_base),
    .seg_bits      (seg)
);

// File: tb/sim_cfgp_port.sv
`timescale 1ns/1ps
module sim_cfgp_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strap_alt_base = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [15:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        cfg_open;
    logic [7:0]  ldn_sel;
    logic [15:0] flash_io_base;
    logic        seg_suspend, seg_top_en, seg_mid_en, seg_448_en;
    logic        flash_host_wr_en, flash_pin_alt;

    int n_cmp = 0;
    int n_bad = 0;
    int wd    = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } exp_t;
    exp_t sb[$];
    logic rd_seen = 1'b0;

    always #4 clk = ~clk;

    cfgp_port u0 (
        .clk(clk), .rst(rst), .strap_alt_base(strap_alt_base),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .cfg_open(cfg_open),
        .ldn_sel(ldn_sel), .flash_io_base(flash_io_base),
        .seg_suspend(seg_suspend), .seg_top_en(seg_top_en), .seg_mid_en(seg_mid_en),
        .seg_448_en(seg_448_en), .flash_host_wr_en(flash_host_wr_en),
        .flash_pin_alt(flash_pin_alt)
    );

    // monitor: a read sampled at a rising edge is compared on the next falling edge
    always @(posedge clk) rd_seen <= host_rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (sb.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL unexpected read result: actual %02h expected none", host_rdata);
            end else begin
                exp_t e;
                e = sb.pop_front();
                n_cmp++;
                if (host_rdata !== e.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %02h expected %02h", e.tag, host_rdata, e.exp);
                end
            end
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 20000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] e, input string tag);
        exp_t x;
        @(negedge clk);
        x.exp = e; x.tag = tag;
        sb.push_back(x);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic key(input logic [15:0] b, input logic [7:0] last);
        wr(b, 8'h87); wr(b, 8'h01); wr(b, 8'h55); wr(b, last);
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        strap_alt_base = strap; rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [5:0] seg_now();
        return {flash_pin_alt, flash_host_wr_en, seg_448_en, seg_mid_en, seg_top_en, seg_suspend};
    endfunction

    initial begin
        do_reset(1'b0);
        // R1 reset state
        chk("R1 open", cfg_open, 0);
        chk("R1 ldn", ldn_sel, 0);
        chk("R1 base", flash_io_base, 16'h0820);
        chk("R1 seg", seg_now(), 0);

        // R4 locked behaviour
        rd(16'h002F, 8'hFF, "R4 locked data read");
        rd(16'h002E, 8'hFF, "R4 locked index read");
        wr(16'h002F, 8'h3F);
        chk("R4 locked write ignored", seg_now(), 0);

        // R2 wrong last byte on primary base
        key(16'h002E, 8'hAA);
        chk("R2 wrong last byte", cfg_open, 0);
        // R3 broken sequence then 0x87 restart
        wr(16'h002E, 8'h87); wr(16'h002E, 8'h01); wr(16'h002E, 8'h33);
        wr(16'h002E, 8'h55);
        chk("R3 broken stays locked", cfg_open, 0);
        wr(16'h002E, 8'h87); wr(16'h002E, 8'h87); wr(16'h002E, 8'h01);
        wr(16'h002E, 8'h55); wr(16'h002E, 8'h55);
        chk("R3 restart by 0x87 opens", cfg_open, 1);

        // R5 index select and readback
        wr(16'h002E, 8'h20);
        rd(16'h002E, 8'h20, "R5 index readback");
        // R6 chip ID
        rd(16'h002F, 8'h87, "R6 id high");
        wr(16'h002E, 8'h21);
        rd(16'h002F, 8'h16, "R6 id low");
        wr(16'h002F, 8'h00);
        rd(16'h002F, 8'h16, "R6 id write ignored");

        // R8 segment control
        wr(16'h002E, 8'h24);
        wr(16'h002F, 8'hFF);
        chk("R8 all bits", seg_now(), 6'h3F);
        rd(16'h002F, 8'h3F, "R8 upper bits read zero");
        wr(16'h002F, 8'h05);
        chk("R8 suspend", seg_suspend, 1);
        chk("R8 mid", seg_mid_en, 1);
        chk("R8 others", {flash_pin_alt, flash_host_wr_en, seg_448_en, seg_top_en}, 0);
        wr(16'h002F, 8'h12);
        chk("R8 top+hostwr", seg_now(), 6'h12);

        // R7 logical device gating
        wr(16'h002E, 8'h07); wr(16'h002F, 8'h03);
        chk("R7 ldn out", ldn_sel, 8'h03);
        wr(16'h002E, 8'h64); wr(16'h002F, 8'h12);
        rd(16'h002F, 8'h00, "R7 foreign ldn reads zero");
        chk("R7 foreign ldn no write", flash_io_base, 16'h0820);
        wr(16'h002E, 8'h07); wr(16'h002F, 8'h07);
        wr(16'h002E, 8'h64); wr(16'h002F, 8'hAB);
        wr(16'h002E, 8'h65); wr(16'h002F, 8'hCD);
        chk("R7 flash base", flash_io_base, 16'hABCD);
        wr(16'h002E, 8'h64);
        rd(16'h002F, 8'hAB, "R7 base high read");

        // R10 undecoded addresses
        wr(16'h004E, 8'h20); wr(16'h004F, 8'h00); wr(16'h0030, 8'h21);
        rd(16'h002E, 8'h64, "R10 other base no index change");
        rd(16'h0030, 8'hFF, "R10 undecoded read");
        rd(16'h004F, 8'hFF, "R10 alt data undecoded");
        // R11 hold
        repeat (3) @(negedge clk);
        chk("R11 rdata holds", host_rdata, 8'hFF);

        // R9 exit
        wr(16'h002E, 8'h02); wr(16'h002F, 8'h01);
        chk("R9 other value keeps open", cfg_open, 1);
        rd(16'h002F, 8'h00, "R9 exit reg reads zero");
        wr(16'h002F, 8'h02);
        chk("R9 exit locks", cfg_open, 0);
        rd(16'h002F, 8'hFF, "R9 locked after exit");
        wr(16'h002F, 8'h00);
        chk("R9 locked hold base", flash_io_base, 16'hABCD);

        // R12 strap change without reset
        @(negedge clk); strap_alt_base = 1'b1;
        key(16'h004E, 8'hAA);
        chk("R12 alt key ignored before reset", cfg_open, 0);
        key(16'h002E, 8'h55);
        chk("R12 primary still live", cfg_open, 1);

        // alternate base after reset
        do_reset(1'b1);
        chk("R1 open after reset", cfg_open, 0);
        chk("R1 base after reset", flash_io_base, 16'h0820);
        key(16'h004E, 8'h55);
        chk("R2 alt wrong last byte", cfg_open, 0);
        key(16'h004E, 8'hAA);
        chk("R2 alt key opens", cfg_open, 1);
        wr(16'h004E, 8'h20);
        rd(16'h004F, 8'h87, "R2 alt data port");
        rd(16'h002F, 8'hFF, "R10 primary undecoded");

        repeat (4) @(negedge clk);
        if (sb.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
        end
        summary();
    end
endmodule